// File: doc/BRIEF.md
# Vector-Length Read Rewriter

This decode-stage block sits in the instruction path of a scalar core where the vector length is held in an ordinary integer register rather than in a dedicated control register. It keeps a 5-bit pointer that names the integer register currently acting as the vector length. A pointer of zero means that no register is marked, and the block then leaves every instruction alone.

Each 32-bit instruction that enters is classified. A vector-configuration instruction loads the pointer from its rs1 field and passes through unchanged. A control-register read of the vector length is replaced, while the pointer is non-zero, by an add-immediate-zero move into the same destination, sourced from the pointed-to register. Scalar dependency tracking further down can then handle it with no special stall path. Every other instruction passes through untouched.

The block is one registered stage with a valid/ready handshake on both sides. A flag marks each emitted instruction that was rewritten.

Top module: `vlrw_top`

## Requirements
- R1: After a synchronous reset, outValid is 0, inReady is 1 and the pointer is zero, so a vector-length read accepted straight after reset leaves the block unchanged with outRewritten = 0.
- R2: A configuration instruction has bits [6:0] = 1010111, bits [14:12] = 111 and bit 31 = 0. When such an instruction is accepted, the pointer loads its bits [19:15]. The instruction itself is emitted unchanged with outRewritten = 0.
- R3: An instruction with opcode 1010111 does not change the pointer if bit 31 = 1 or if bits [14:12] are not 111.
- R4: A vector-length read has opcode 1110011, bits [14:12] = 010, bits [19:15] = 0 and bits [31:20] = 0xC20. If such a read is accepted while the pointer P is non-zero, the block emits {12'h000, P, 3'b000, rd, 7'b0010011} with outRewritten = 1. Here rd is bits [11:7] of the input.
- R5: A vector-length read accepted while the pointer is zero is emitted unchanged with outRewritten = 0.
- R6: A system instruction that does not match every field of R4 is emitted unchanged with outRewritten = 0. This covers another address, a non-zero bits [19:15], or bits [14:12] other than 010.
- R7: A pointer loaded by a configuration instruction applies to the very next accepted instruction, including one accepted in the following cycle.
- R8: inReady is 1 exactly when outValid is 0 or outReady is 1. While outValid = 1 and outReady = 0, outValid, outInstr and outRewritten hold their values.
- R9: Every accepted instruction is emitted exactly once, in the order of acceptance, one cycle after acceptance at the earliest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Upstream has an instruction |
| inReady | output | 1 | Block can take an instruction this cycle |
| inInstr | input | 32 | Incoming instruction word |
| outValid | output | 1 | Emitted instruction is valid |
| outReady | input | 1 | Downstream takes the emitted instruction |
| outInstr | output | 32 | Emitted instruction, rewritten or original |
| outRewritten | output | 1 | Emitted instruction is a rewritten move |

## Verification
The properties assume that the downstream side obeys the handshake. A held output is only observed while outReady is 0, and the upstream keeps inInstr steady while inValid waits for inReady. The scoreboard driver holds each word until it sees inReady at the falling edge, and it changes inputs only shortly after a rising edge. The stall generator drives outReady only from a counter pattern, so long back-pressure runs mix with back-to-back transfers. This exercises R7 both with a gap after a pointer load and with none.

// File: rtl/vlrw_pkg.sv
`timescale 1ns/1ps
package vlrw_pkg;
  localparam int INSTR_W   = 32;
  localparam int REG_IDX_W = 5;
  localparam int CSR_W     = 12;

  localparam logic [6:0] OPC_VCFG   = 7'b1010111;
  localparam logic [2:0] F3_VCFG    = 3'b111;
  localparam logic [6:0] OPC_SYSTEM = 7'b1110011;
  localparam logic [2:0] F3_CSRRS   = 3'b010;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [2:0] F3_ADDI    = 3'b000;

  // strobes from control to datapath
  typedef struct packed {
    logic take;     // an instruction is accepted this cycle
    logic loadPtr;  // accepted word is a configuration instruction
    logic swap;     // accepted word must be replaced by a move
  } strobe_t;

  // hi = instr[31:12], opc = instr[6:0]
  function automatic logic isVlCfg(input logic [19:0] hi, input logic [6:0] opc);
    return (opc == OPC_VCFG) && (hi[2:0] == F3_VCFG) && !hi[19];
  endfunction

  function automatic logic isVlRead(input logic [19:0] hi, input logic [6:0] opc,
                                    input logic [CSR_W-1:0] csrAddr);
    return (opc == OPC_SYSTEM) && (hi[2:0] == F3_CSRRS) &&
           (hi[7:3] == '0) && (hi[19:8] == csrAddr);
  endfunction
endpackage

// File: rtl/vlrw_ctrl.sv
`timescale 1ns/1ps
module vlrw_ctrl
  import vlrw_pkg::*;
#(
  parameter logic [CSR_W-1:0] VL_CSR_ADDR = 12'hC20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  output logic          inReady,
  input  logic [19:0]   instrHi,
  input  logic [6:0]    instrOpc,
  input  logic          outReady,
  output logic          outValid,
  input  logic          ptrLive,
  output strobe_t       strobe
);
  logic validQ;
  logic takeNow;

  assign inReady  = !validQ || outReady;
  assign takeNow  = inValid && inReady;
  assign outValid = validQ;

  always_comb begin
    strobe.take    = takeNow;
    strobe.loadPtr = takeNow && isVlCfg(instrHi, instrOpc);
    strobe.swap    = takeNow && ptrLive && isVlRead(instrHi, instrOpc, VL_CSR_ADDR);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      validQ <= 1'b0;
    end else if (takeNow) begin
      validQ <= 1'b1;
    end else if (outReady) begin
      validQ <= 1'b0;
    end
  end
endmodule

// File: rtl/vlrw_datapath.sv
`timescale 1ns/1ps
module vlrw_datapath
  import vlrw_pkg::*;
#(
  parameter int IDX_W = REG_IDX_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] inInstr,
  input  strobe_t            strobe,
  output logic [INSTR_W-1:0] outInstr,
  output logic               outRewritten,
  output logic               ptrLive
);
  localparam int RS1_LSB = 15;
  localparam int RD_LSB  = 7;
  localparam int IMM_W   = INSTR_W - IDX_W - 3 - IDX_W - 7;

  logic [IDX_W-1:0]   vlPtr;
  logic [INSTR_W-1:0] moveInstr;

  assign ptrLive = (vlPtr != '0);

  assign moveInstr = {{IMM_W{1'b0}}, vlPtr, F3_ADDI,
                      inInstr[RD_LSB +: IDX_W], OPC_OPIMM};

  always_ff @(posedge clk) begin
    if (rst) begin
      vlPtr <= '0;
    end else if (strobe.loadPtr) begin
      vlPtr <= inInstr[RS1_LSB +: IDX_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outInstr     <= '0;
      outRewritten <= 1'b0;
    end else if (strobe.take) begin
      outInstr     <= strobe.swap ? moveInstr : inInstr;
      outRewritten <= strobe.swap;
    end
  end
endmodule

// File: rtl/vlrw_top.sv
`timescale 1ns/1ps
module vlrw_top
  import vlrw_pkg::*;
#(
  parameter logic [CSR_W-1:0] VL_CSR_ADDR = 12'hC20
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output logic        inReady,
  input  logic [31:0] inInstr,
  output logic        outValid,
  input  logic        outReady,
  output logic [31:0] outInstr,
  output logic        outRewritten
);
  strobe_t strobe;
  logic    ptrLive;

  vlrw_ctrl #(.VL_CSR_ADDR(VL_CSR_ADDR)) ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inReady  (inReady),
    .instrHi  (inInstr[31:12]),
    .instrOpc (inInstr[6:0]),
    .outReady (outReady),
    .outValid (outValid),
    .ptrLive  (ptrLive),
    .strobe   (strobe)
  );

  vlrw_datapath #(.IDX_W(REG_IDX_W)) dpath (
    .clk          (clk),
    .rst          (rst),
    .inInstr      (inInstr),
    .strobe       (strobe),
    .outInstr     (outInstr),
    .outRewritten (outRewritten),
    .ptrLive      (ptrLive)
  );
endmodule

// File: rtl/vlrw_checker.sv
`timescale 1ns/1ps
module vlrw_checker (
  input logic        clk,
  input logic        rst,
  input logic        inValid,
  input logic        inReady,
  input logic        outValid,
  input logic        outReady,
  input logic [31:0] outInstr,
  input logic        outRewritten
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> !outValid);

  // R8
  stall_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |-> !inReady);

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outInstr) && $stable(outRewritten)));

  // R9
  accept_emits_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |=> outValid);

  // R4
  move_form_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && outRewritten) |-> (outInstr[6:0] == 7'b0010011 &&
      outInstr[14:12] == 3'b000 && outInstr[31:20] == 12'h000 &&
      outInstr[19:15] != 5'd0));

  // R2
  cfg_untouched_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && outInstr[6:0] == 7'b1010111) |-> !outRewritten);
endmodule

bind vlrw_top vlrw_checker chk (
  .clk          (clk),
  .rst          (rst),
  .inValid      (inValid),
  .inReady      (inReady),
  .outValid     (outValid),
  .outReady     (outReady),
  .outInstr     (outInstr),
  .outRewritten (outRewritten)
);

// File: tb/vlrw_top_test.sv
`timescale 1ns/1ps
module vlrw_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] inInstr = '0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [31:0] outInstr;
  logic        outRewritten;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 0;

  logic [32:0] expQ[$];
  string       tagQ[$];
  logic [4:0]  modelPtr = '0;
  bit          stallMode = 0;
  int          stallCnt = 0;
  logic [31:0] lfsr = 32'h1D2C3B4A;

  always #4 clk = ~clk;  // 125 MHz

  vlrw_top uut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .inInstr(inInstr), .outValid(outValid), .outReady(outReady),
    .outInstr(outInstr), .outRewritten(outRewritten)
  );

  task automatic check(input bit ok, input string tag, input logic [32:0] act, input logic [32:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] csrRd(input logic [4:0] rd, input logic [11:0] csr,
                                        input logic [4:0] rs1, input logic [2:0] f3);
    return {csr, rs1, f3, rd, 7'b1110011};
  endfunction

  function automatic logic [31:0] cfgOp(input logic b31, input logic [2:0] f3,
                                        input logic [4:0] rs1, input logic [4:0] rd);
    return {b31, 6'b010101, 5'b00110, rs1, f3, rd, 7'b1010111};
  endfunction

  // expected output computed from R2..R6
  function automatic logic [32:0] predict(input logic [31:0] w);
    bit isRead;
    isRead = (w[6:0] == 7'b1110011) && (w[14:12] == 3'b010) &&
             (w[19:15] == 5'd0) && (w[31:20] == 12'hC20);
    if (isRead && modelPtr != 5'd0)
      return {1'b1, 12'h000, modelPtr, 3'b000, w[11:7], 7'b0010011};
    return {1'b0, w};
  endfunction

  task automatic send(input logic [31:0] w, input string tag);
    expQ.push_back(predict(w));
    tagQ.push_back(tag);
    if (w[6:0] == 7'b1010111 && w[14:12] == 3'b111 && !w[31])
      modelPtr = w[19:15];
    inInstr = w;
    inValid = 1'b1;
    forever begin
      @(negedge clk);
      if (inReady) break;
    end
    @(posedge clk);
    #2;
    inValid = 1'b0;
  endtask

  // downstream stall pattern
  always @(posedge clk) begin
    #2;
    stallCnt++;
    outReady <= stallMode ? ((stallCnt % 5) < 2 || (stallCnt % 11) == 0) : 1'b1;
  end

  // monitor / scoreboard
  logic [32:0] heldVal;
  bit          heldPend = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (heldPend)
        check(outValid && {outRewritten, outInstr} == heldVal, "R8 hold",
              {outRewritten, outInstr}, heldVal);
      heldPend = outValid && !outReady;
      heldVal  = {outRewritten, outInstr};
      if (outValid && outReady) begin
        if (expQ.size() == 0) begin
          check(0, "R9 extra output", {outRewritten, outInstr}, '0);
        end else begin
          logic [32:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check({outRewritten, outInstr} == e, t, {outRewritten, outInstr}, e);
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired actual=%0d expected=0", expQ.size());
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    check(!outValid && inReady, "R1 reset state", {31'd0, outValid, inReady}, 33'd1);
    @(posedge clk); #2;

    send(csrRd(5'd5, 12'hC20, 5'd0, 3'b010), "R1 read after reset");
    send(cfgOp(1'b1, 3'b111, 5'd7, 5'd1), "R3 cfg bit31 set");
    send(csrRd(5'd6, 12'hC20, 5'd0, 3'b010), "R3 pointer kept zero");
    send(cfgOp(1'b0, 3'b110, 5'd7, 5'd1), "R3 cfg funct3 other");
    send(csrRd(5'd6, 12'hC20, 5'd0, 3'b010), "R5 read with zero pointer");
    send(cfgOp(1'b0, 3'b111, 5'd9, 5'd2), "R2 cfg passes");
    send(csrRd(5'd3, 12'hC20, 5'd0, 3'b010), "R7 back-to-back read");
    send(csrRd(5'd0, 12'hC20, 5'd0, 3'b010), "R4 rd zero");
    send(csrRd(5'd31, 12'hC20, 5'd0, 3'b010), "R4 rd 31");
    send(csrRd(5'd4, 12'hC21, 5'd0, 3'b010), "R6 other address");
    send(csrRd(5'd4, 12'hC20, 5'd4, 3'b010), "R6 rs1 nonzero");
    send(csrRd(5'd4, 12'hC20, 5'd0, 3'b001), "R6 other funct3");
    send(cfgOp(1'b0, 3'b111, 5'd31, 5'd0), "R2 cfg to 31");
    send(csrRd(5'd8, 12'hC20, 5'd0, 3'b010), "R7 read after load 31");
    send(cfgOp(1'b0, 3'b111, 5'd0, 5'd0), "R2 cfg to zero");
    send(csrRd(5'd8, 12'hC20, 5'd0, 3'b010), "R5 read after clear");

    stallMode = 1;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      case (lfsr[2:0])
        3'd0, 3'd1: send(cfgOp(lfsr[3] & lfsr[4], lfsr[4] ? 3'b111 : 3'b101, lfsr[9:5], lfsr[14:10]), "R2 random cfg");
        3'd2, 3'd3, 3'd4: send(csrRd(lfsr[9:5], 12'hC20, 5'd0, 3'b010), "R4 random read");
        3'd5: send(csrRd(lfsr[9:5], {11'h610, lfsr[10]}, lfsr[11] ? lfsr[16:12] : 5'd0, 3'b010), "R6 random near-miss");
        default: send(lfsr, "R9 random word");
      endcase
      if (lfsr[20] && lfsr[21]) begin
        repeat (2) @(posedge clk);
        #2;
      end
    end

    stallMode = 0;
    for (int k = 0; k < 200 && expQ.size() != 0; k++) @(posedge clk);
    @(negedge clk);
    check(expQ.size() == 0, "R9 all emitted", expQ.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule